// File: doc/BRIEF.md
# Sticky Event Status Register with Mask and Summary

This block collects eight single-cycle event pulses into sticky status bits, one per event source. A mask register selects which recorded events may raise the active-high, level-sensitive interrupt line and the global summary flag. A CPU clears all status bits at once by reading the status register. The events belong to two serial-link channels: one pool-ready event from the second channel and seven transmit and receive events from the third.

A global visibility switch sets how masked events are handled. With the switch off, a masked event is dropped and leaves no trace. With it on, the masked event is still written into the status register, so software can poll for it. Masked bits never reach the interrupt line or the summary flag, whatever the switch setting. Unmasking a bit that is already recorded makes it visible on both outputs.

The register file sits on a simple strobe bus. A read returns data combinationally in the strobe cycle. A write or a clearing read takes effect at the clock edge that ends the strobe. The asynchronous reset is released in step with the clock.

Top module: `irq_stat_top`

## Requirements
- R1: After reset the status register reads 0x00, the mask register reads 0xFF, the visibility bit reads 0, and both irq_o and gsum_o are low.
- R2: A one-cycle pulse on an unmasked evt_i bit sets the matching status bit at the clock edge that ends the pulse. The bit then stays set, without further pulses, until the status register is read.
- R3: A bus read of address 0 returns the status register in the strobe cycle and clears every status bit at the edge that ends the strobe.
- R4: An event pulse that falls in the same cycle as a clearing read is recorded, so its bit is set after that read.
- R5: With the visibility bit at 0, a pulse on a masked bit (mask bit = 1) leaves its status bit at 0.
- R6: With the visibility bit at 1, a pulse on a masked bit sets its status bit just as an unmasked pulse would.
- R7: irq_o is high exactly when at least one status bit is set whose mask bit is 0. Set bits that are masked never drive it, in either visibility mode.
- R8: gsum_o follows the same rule as irq_o: it is high exactly when some set status bit is unmasked.
- R9: Address 1 is the read/write mask register, with bit n masking event n. Address 2 bit 0 is the visibility bit and reads back in bit 0, with the upper bits reading 0. Address 3 reads 0x00. Reads of addresses 1 to 3 leave the status bits unchanged.
- R10: evt_i bit n feeds status bit n. From bit 7 down to bit 0 the events are: channel 2 transmit pool ready, channel 3 transmit pool ready, channel 3 receive message end, channel 3 receive frame start, channel 3 receive data overflow, channel 3 all sent, channel 3 transmit underrun, channel 3 receive pool full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 8 | Event pulses, one cycle wide, bit order per R10 |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read strobe cycle |
| irq_o | output | 1 | Active-high level interrupt |
| gsum_o | output | 1 | Global summary flag for this register |

## Verification
An event pulse, a mask write or a visibility write changes state at the edge that ends its cycle. irq_o and gsum_o follow that state with no further register delay, so the bench checks them one cycle after the stimulus. Read data is combinational and is sampled 1 ns after the strobe is driven, before the edge. The clearing effect is checked on the following cycle. All stimulus is driven on falling edges and all outputs are sampled away from rising edges. The sweeps cover every status pattern and every mask value in both visibility modes, and the expected values are built from bitwise arithmetic on the applied pattern.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned NUM_EVT = 8;
  localparam int unsigned ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd2;

  // event bit positions (R10)
  typedef enum int unsigned {
    EV_C3_RX_POOL_FULL  = 0,
    EV_C3_TX_UNDERRUN   = 1,
    EV_C3_ALL_SENT      = 2,
    EV_C3_RX_OVERFLOW   = 3,
    EV_C3_RX_FRAME_BEG  = 4,
    EV_C3_RX_MSG_END    = 5,
    EV_C3_TX_POOL_RDY   = 6,
    EV_C2_TX_POOL_RDY   = 7
  } evt_pos_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      mask_q,
  output logic              vis_q
);
  import irq_stat_pkg::*;

  logic          mask_en, vis_en;
  logic [W-1:0]  mask_d;
  logic          vis_d;

  always_comb begin
    mask_en = bus_wr && (bus_addr == ADR_MASK);
    vis_en  = bus_wr && (bus_addr == ADR_CTRL);
    mask_d  = bus_wdata;
    vis_d   = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vis_q <= 1'b0;
    else if (vis_en) vis_q <= vis_d;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] mask_q,
  input  logic         vis_q,
  input  logic [W-1:0] stat_q,
  output logic [W-1:0] set_o,
  output logic         irq_o,
  output logic         gsum_o
);
  logic [W-1:0] live;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign set_o[i] = evt_i[i] & (vis_q | ~mask_q[i]);
    assign live[i]  = stat_q[i] & ~mask_q[i];
  end

  assign irq_o  = |live;
  assign gsum_o = |live;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] stat_d;
  logic         upd;

  always_comb begin
    stat_d = (clr_i ? '0 : stat_q) | set_i;
    upd    = clr_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat_q <= '0;
    else if (upd) stat_q <= stat_d;
  end
endmodule

// File: rtl/irq_stat_top.sv
module irq_stat_top
  import irq_stat_pkg::*;
#(
  parameter int unsigned W = NUM_EVT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      evt_i,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_o,
  output logic              gsum_o
);
  logic          rst_sync_n;
  logic [W-1:0]  mask_q, stat_q, set_w;
  logic          vis_q, rd_stat;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  irq_cfg_regs #(.W(W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mask_q(mask_q), .vis_q(vis_q)
  );

  irq_gate #(.W(W)) u_gate (
    .evt_i(evt_i), .mask_q(mask_q), .vis_q(vis_q), .stat_q(stat_q),
    .set_o(set_w), .irq_o(irq_o), .gsum_o(gsum_o)
  );

  assign rd_stat = bus_rd && (bus_addr == ADR_STAT);

  irq_status_reg #(.W(W)) u_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_i(set_w), .clr_i(rd_stat),
    .stat_q(stat_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        ADR_STAT: bus_rdata = stat_q;
        ADR_MASK: bus_rdata = mask_q;
        ADR_CTRL: bus_rdata = {{(W-1){1'b0}}, vis_q};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic [W-1:0] evt_i,
  input logic         rd_stat,
  input logic [W-1:0] stat_q,
  input logic [W-1:0] mask_q,
  input logic         vis_q,
  input logic         irq_o,
  input logic         gsum_o
);
  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stat && evt_i == '0) |=> (stat_q == '0)); // R3

  AST_EVT_KEPT_ON_CLR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stat && vis_q) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_stat) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2

  AST_NO_MASKED_LATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!vis_q && !rd_stat) |=> (((stat_q & ~$past(stat_q)) & $past(mask_q)) == '0)); // R5

  AST_VIS_LATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vis_q |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R6

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((stat_q & ~mask_q) == '0) |-> !irq_o); // R7

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gsum_o == irq_o); // R8
endmodule

bind irq_stat_top irq_stat_chk #(.W(W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .evt_i(evt_i), .rd_stat(rd_stat),
  .stat_q(stat_q), .mask_q(mask_q), .vis_q(vis_q), .irq_o(irq_o),
  .gsum_o(gsum_o)
);

// File: tb/irq_stat_top_tb_top.sv
`timescale 1ns/1ps
module irq_stat_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_i, bus_wdata, bus_rdata;
  logic       bus_rd, bus_wr;
  logic [1:0] bus_addr;
  logic       irq_o, gsum_o;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  irq_stat_top dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .gsum_o(gsum_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic outs(input string req, input logic exp);
    check({req, " irq_o"}, {7'd0, irq_o}, {7'd0, exp});
    check({req, " gsum_o"}, {7'd0, gsum_o}, {7'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; evt_i = '0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    outs("R1", 1'b0);
    rd(2'd1, d); check("R1 mask", d, 8'hFF);
    rd(2'd2, d); check("R1 vis", d, 8'h00);
    rd(2'd0, d); check("R1 status", d, 8'h00);

    // R2 R3 R10 single bits, sticky
    wr(2'd1, 8'h00);
    for (int b = 0; b < 8; b++) begin
      pulse(8'(1 << b));
      repeat (2) @(negedge clk);
      outs("R2", 1'b1);
      rd(2'd0, d); check("R10 bit position", d, 8'(1 << b));
      outs("R3 after clear", 1'b0);
      rd(2'd0, d); check("R3 cleared", d, 8'h00);
    end

    // R3 every status pattern
    for (int p = 0; p < 256; p++) begin
      pulse(8'(p));
      outs("R7 pattern", p != 0);
      rd(2'd0, d); check("R3 pattern", d, 8'(p));
      rd(2'd0, d); check("R3 cleared", d, 8'h00);
    end

    // R5 visibility off, every mask
    for (int m = 0; m < 256; m++) begin
      wr(2'd1, 8'(m));
      pulse(8'hFF);
      outs("R7 vis0", m != 255);
      rd(2'd0, d); check("R5 masked dropped", d, ~8'(m));
    end

    // R6 visibility on, every mask
    wr(2'd2, 8'h01);
    rd(2'd2, d); check("R9 vis readback", d, 8'h01);
    for (int m = 0; m < 256; m++) begin
      wr(2'd1, 8'(m));
      pulse(8'hFF);
      outs("R7 R8 vis1", m != 255);
      rd(2'd0, d); check("R6 masked recorded", d, 8'hFF);
    end

    // R7 unmasking a recorded bit shows it
    wr(2'd1, 8'hFF);
    pulse(8'h10);
    outs("R7 masked", 1'b0);
    wr(2'd1, 8'hEF);
    outs("R7 unmasked", 1'b1);

    // R9 other reads keep status
    rd(2'd1, d); check("R9 mask readback", d, 8'hEF);
    rd(2'd3, d); check("R9 addr3", d, 8'h00);
    rd(2'd2, d); check("R9 vis", d, 8'h01);
    rd(2'd0, d); check("R9 status kept", d, 8'h10);

    // R4 event with clearing read, both modes
    wr(2'd1, 8'h00);
    for (int v = 0; v < 2; v++) begin
      wr(2'd2, 8'(v));
      pulse(8'h84);
      evt_i = 8'h21;
      rd(2'd0, d); check("R4 read data", d, 8'h84);
      evt_i = '0;
      rd(2'd0, d); check("R4 event kept", d, 8'h21);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule